// File: doc/BRIEF.md
# I2C Target Pin Expander

This block is an I2C target that gives a controller eight general-purpose pins. It works from a small set of four registers. One register reports the pin levels. One holds the values to drive. One flips pin polarity bit by bit. One chooses the direction of each pin. The bus lines are brought into the system clock domain through a synchroniser. START and STOP are found from SDA edges that occur while SCL is high. Data bits are taken only on SCL rising edges.

The target answers a single fixed 7-bit device address. It drives SDA only through a pull-low enable, so the line is never driven high.

- **Write:** the controller sends the address with the write bit, then a command byte that selects a register, then one or more data bytes. All data bytes go to that same register.
- **Read:** the controller writes the command byte, issues a repeated START, and sends the address with the read bit. The target then returns the selected register once per byte until the controller answers with a not-acknowledge.

Top module: `pin_expander_i2c`

## Requirements
- R1: After reset every pin is an input (`pin_oe_o` = 0x00) and `pin_do_o` = 0xFF. Reading command 0x01 returns 0xFF, command 0x02 returns 0x00 and command 0x03 returns 0xFF.
- R2: After a matching address with write bit, the target acknowledges by pulling SDA low during the ninth clock. This applies to the address byte, a command byte 0x01, 0x02 or 0x03, and each data byte. The data byte is stored in the selected register and reads back unchanged.
- R3: A command byte above 0x03 is not acknowledged, since SDA stays high in the ninth clock. The data bytes that follow are not acknowledged either, and no register changes.
- R4: An address byte whose upper seven bits differ from the device address is not acknowledged. Every following byte is also not acknowledged, and no register changes, until the next START.
- R5: Command 0x00 reads back `pin_i` XOR the polarity register (command 0x02). A write to command 0x00 is acknowledged but changes no register.
- R6: Register 0x03 sets direction per pin: bit value 1 means input, 0 means output. `pin_oe_o[i]` is the inverse of bit i.
- R7: `pin_do_o[i]` equals bit i of register 0x01 XOR bit i of register 0x02.
- R8: SDA is only ever pulled low or released. The pull-low enable changes only while SCL is low, except when a START or STOP clears it.
- R9: Bits are taken only at SCL rising edges. Pulses on SDA while SCL is low do not change the decoded bytes.
- R10: In a read, the target keeps returning the selected register for as long as the controller acknowledges. It releases SDA after the byte the controller does not acknowledge.
- R11: A START or STOP at any bit position abandons the byte in progress without writing anything. A START then begins a new address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | When high, the pad pulls SDA low; otherwise SDA is released |
| pin_i | input | NPINS | Levels seen on the general-purpose pins |
| pin_oe_o | output | NPINS | Per-pin output enable (1 = pin driven) |
| pin_do_o | output | NPINS | Per-pin drive value, after polarity flip |

## Verification
The hardest state to reach from the ports is a transaction cut off partway through a byte: after the address and command have been acknowledged and some data bits have been clocked in, or partway through the address byte itself. The bench gets there with bus tasks that clock in a chosen number of single bits and then issue a STOP or a repeated START at that bit position. It then reads the registers back and watches the pins to show that nothing was written, and that the next START was decoded cleanly. A second hard case is SDA bouncing while SCL is low. A switchable glitch mode in the bit task toggles SDA just before each settled bit, and writes and read-backs are run under that mode.

// File: rtl/xp_pkg.sv
package xp_pkg;
   localparam int BYTE_W = 8;
   localparam logic [BYTE_W-1:0] LAST_CMD = 8'h03;

   typedef enum logic [1:0] {
      SEL_LEVEL = 2'd0,
      SEL_DRIVE = 2'd1,
      SEL_FLIP  = 2'd2,
      SEL_DIR   = 2'd3
   } sel_t;

   typedef enum logic [2:0] {
      LK_IDLE,
      LK_ADDR,
      LK_CMD,
      LK_WDAT,
      LK_ACK,
      LK_TX,
      LK_RACK
   } lk_state_t;
endpackage

// File: rtl/xp_sync.sv
module xp_sync #(
   parameter int            W       = 1,
   parameter int            STAGES  = 2,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] chain;

   initial begin
      assert (STAGES >= 2) else $error("xp_sync: STAGES must be at least 2");
      assert (W >= 1) else $error("xp_sync: W must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/xp_bus_events.sv
module xp_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise = scl_s & ~scl_q;
   assign scl_fall = ~scl_s & scl_q;
   assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/xp_link.sv
module xp_link
   import xp_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h27
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_s,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_ev,
   input  logic              stop_ev,
   input  logic [BYTE_W-1:0] rd_data,
   output sel_t              sel,
   output logic              wr_en,
   output logic [BYTE_W-1:0] wr_data,
   output logic              sda_pull
);
   lk_state_t         state, after;
   logic [3:0]        bitcnt;
   logic [BYTE_W-1:0] sr, tx;
   logic              pull, more;
   sel_t              sel_q;
   logic              wr_en_q;
   logic [BYTE_W-1:0] wr_data_q;

   logic byte_done, addr_hit, cmd_ok, in_byte;
   assign byte_done = scl_fall && (bitcnt == 4'd8);
   assign in_byte   = scl_rise && (bitcnt < 4'd8);
   assign addr_hit  = (sr[7:1] == DEV_ADDR);
   assign cmd_ok    = (sr <= LAST_CMD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= LK_IDLE;
         after     <= LK_IDLE;
         bitcnt    <= '0;
         sr        <= '0;
         tx        <= '0;
         pull      <= 1'b0;
         more      <= 1'b0;
         sel_q     <= SEL_LEVEL;
         wr_en_q   <= 1'b0;
         wr_data_q <= '0;
      end else begin
         wr_en_q <= 1'b0;
         if (start_ev) begin
            state  <= LK_ADDR;
            bitcnt <= '0;
            pull   <= 1'b0;
         end else if (stop_ev) begin
            state <= LK_IDLE;
            pull  <= 1'b0;
         end else begin
            case (state)
               LK_ADDR, LK_CMD, LK_WDAT: begin
                  if (in_byte) begin
                     sr     <= {sr[BYTE_W-2:0], sda_s};
                     bitcnt <= bitcnt + 4'd1;
                  end else if (byte_done) begin
                     if (state == LK_ADDR) begin
                        if (addr_hit) begin
                           pull  <= 1'b1;
                           state <= LK_ACK;
                           after <= sr[0] ? LK_TX : LK_CMD;
                        end else begin
                           state <= LK_IDLE;
                        end
                     end else if (state == LK_CMD) begin
                        if (cmd_ok) begin
                           pull  <= 1'b1;
                           sel_q <= sel_t'(sr[1:0]);
                           state <= LK_ACK;
                           after <= LK_WDAT;
                        end else begin
                           state <= LK_IDLE;
                        end
                     end else begin
                        pull      <= 1'b1;
                        wr_en_q   <= 1'b1;
                        wr_data_q <= sr;
                        state     <= LK_ACK;
                        after     <= LK_WDAT;
                     end
                  end
               end
               LK_ACK: begin
                  if (scl_fall) begin
                     bitcnt <= '0;
                     state  <= after;
                     if (after == LK_TX) begin
                        tx   <= rd_data;
                        pull <= ~rd_data[BYTE_W-1];
                     end else begin
                        pull <= 1'b0;
                     end
                  end
               end
               LK_TX: begin
                  if (scl_rise) begin
                     bitcnt <= bitcnt + 4'd1;
                  end else if (scl_fall) begin
                     if (bitcnt == 4'd8) begin
                        pull  <= 1'b0;
                        state <= LK_RACK;
                     end else begin
                        tx   <= {tx[BYTE_W-2:0], 1'b0};
                        pull <= ~tx[BYTE_W-2];
                     end
                  end
               end
               LK_RACK: begin
                  if (scl_rise) begin
                     more <= ~sda_s;
                  end else if (scl_fall) begin
                     if (more) begin
                        tx     <= rd_data;
                        pull   <= ~rd_data[BYTE_W-1];
                        bitcnt <= '0;
                        state  <= LK_TX;
                     end else begin
                        state <= LK_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sel      = sel_q;
   assign wr_en    = wr_en_q;
   assign wr_data  = wr_data_q;
   assign sda_pull = pull;

   // R8
   pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($changed(pull) && !$past(start_ev || stop_ev)) |-> !$past(scl_s));

   // R3
   bad_cmd_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == LK_CMD && byte_done && !cmd_ok && !start_ev && !stop_ev)
      |=> (!pull && state == LK_IDLE));

   // R4
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == LK_IDLE) |-> (!pull && !wr_en_q));
endmodule

// File: rtl/xp_regs.sv
module xp_regs
   import xp_pkg::*;
#(
   parameter int                NPINS   = 8,
   parameter int                STAGES  = 2,
   parameter logic [NPINS-1:0]  OUT_RST = '1,
   parameter logic [NPINS-1:0]  POL_RST = '0,
   parameter logic [NPINS-1:0]  DIR_RST = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NPINS-1:0]  pin_i,
   input  sel_t              sel,
   input  logic              wr_en,
   input  logic [BYTE_W-1:0] wr_data,
   output logic [BYTE_W-1:0] rd_data,
   output logic [NPINS-1:0]  pin_oe_o,
   output logic [NPINS-1:0]  pin_do_o
);
   logic [NPINS-1:0] out_q, pol_q, dir_q, pin_s;

   initial begin
      assert (NPINS >= 1 && NPINS <= BYTE_W) else $error("xp_regs: NPINS out of range");
   end

   xp_sync #(.W(NPINS), .STAGES(STAGES), .RST_VAL('0)) u_pin_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_i),
      .q     (pin_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= OUT_RST;
         pol_q <= POL_RST;
         dir_q <= DIR_RST;
      end else if (wr_en) begin
         case (sel)
            SEL_DRIVE: out_q <= wr_data[NPINS-1:0];
            SEL_FLIP:  pol_q <= wr_data[NPINS-1:0];
            SEL_DIR:   dir_q <= wr_data[NPINS-1:0];
            default:   ;
         endcase
      end
   end

   always_comb begin
      rd_data = '0;
      case (sel)
         SEL_LEVEL: rd_data[NPINS-1:0] = pin_s ^ pol_q;
         SEL_DRIVE: rd_data[NPINS-1:0] = out_q;
         SEL_FLIP:  rd_data[NPINS-1:0] = pol_q;
         default:   rd_data[NPINS-1:0] = dir_q;
      endcase
   end

   generate
      for (genvar p = 0; p < NPINS; p++) begin : g_pin
         assign pin_oe_o[p] = ~dir_q[p];
         assign pin_do_o[p] = out_q[p] ^ pol_q[p];
      end
   endgenerate

   // R5
   level_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == SEL_LEVEL) |=> $stable({out_q, pol_q, dir_q}));

   // R2
   drive_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == SEL_DRIVE) |=> (out_q == $past(wr_data[NPINS-1:0])));
endmodule

// File: rtl/pin_expander_i2c.sv
module pin_expander_i2c
   import xp_pkg::*;
#(
   parameter logic [6:0]        DEV_ADDR    = 7'h27,
   parameter int                NPINS       = 8,
   parameter int                SYNC_STAGES = 2,
   parameter logic [NPINS-1:0]  OUT_RST     = '1,
   parameter logic [NPINS-1:0]  POL_RST     = '0,
   parameter logic [NPINS-1:0]  DIR_RST     = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             sda_pull_o,
   input  logic [NPINS-1:0] pin_i,
   output logic [NPINS-1:0] pin_oe_o,
   output logic [NPINS-1:0] pin_do_o
);
   logic [1:0]        bus_s;
   logic              scl_rise, scl_fall, start_ev, stop_ev;
   logic [BYTE_W-1:0] rd_data, wr_data;
   logic              wr_en;
   sel_t              sel;

   xp_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_bus_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({scl_i, sda_i}),
      .q     (bus_s)
   );

   xp_bus_events u_events (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_s    (bus_s[1]),
      .sda_s    (bus_s[0]),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_ev (start_ev),
      .stop_ev  (stop_ev)
   );

   xp_link #(.DEV_ADDR(DEV_ADDR)) u_link (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_s    (bus_s[1]),
      .sda_s    (bus_s[0]),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_ev (start_ev),
      .stop_ev  (stop_ev),
      .rd_data  (rd_data),
      .sel      (sel),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .sda_pull (sda_pull_o)
   );

   xp_regs #(
      .NPINS   (NPINS),
      .STAGES  (SYNC_STAGES),
      .OUT_RST (OUT_RST),
      .POL_RST (POL_RST),
      .DIR_RST (DIR_RST)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_i    (pin_i),
      .sel      (sel),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .rd_data  (rd_data),
      .pin_oe_o (pin_oe_o),
      .pin_do_o (pin_do_o)
   );
endmodule

// File: tb/sim_pin_expander_i2c.sv
module sim_pin_expander_i2c;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 12;
   localparam int WATCHDOG   = 150000;
   localparam logic [6:0] DEV = 7'h27;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic [7:0] pin_drv = 8'hA5;
   logic       sda_pull;
   logic [7:0] oe, dout;
   wire        sda_line = sda_m & ~sda_pull;

   always #(CLK_PERIOD/2) clk = ~clk;

   pin_expander_i2c #(.DEV_ADDR(DEV)) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_m),
      .sda_i      (sda_line),
      .sda_pull_o (sda_pull),
      .pin_i      (pin_drv),
      .pin_oe_o   (oe),
      .pin_do_o   (dout)
   );

   int total = 0;
   int bad   = 0;
   bit glitch_en = 1'b0;
   bit done = 1'b0;
   logic [7:0] out_m = 8'hFF, pol_m = 8'h00, dir_m = 8'hFF;

   typedef struct { string tag; logic [8:0] val; } item_t;
   item_t      exp_q[$];
   logic [8:0] obs_q[$];

   task automatic push_exp(input string tag, input logic [8:0] v);
      item_t it;
      it.tag = tag;
      it.val = v;
      exp_q.push_back(it);
   endtask

   task automatic push_obs(input logic [8:0] v);
      obs_q.push_back(v);
   endtask

   // monitor: pops observed results and compares with the expected queue
   initial begin
      forever begin
         @(negedge clk);
         while (obs_q.size() > 0) begin
            logic [8:0] v;
            v = obs_q.pop_front();
            total++;
            if (exp_q.size() == 0) begin
               bad++;
               $display("FAIL unexpected result: actual=%h expected=none", v);
            end else begin
               item_t it;
               it = exp_q.pop_front();
               if (v !== it.val) begin
                  bad++;
                  $display("FAIL %s: actual=%h expected=%h", it.tag, v, it.val);
               end
            end
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bit_w(input bit b);
      if (glitch_en) begin
         sda_m = ~b;
         idle(2);
         sda_m = b;
         idle(1);
         sda_m = ~b;
         idle(1);
      end
      sda_m = b;
      idle(HALF);
      scl_m = 1'b1;
      idle(HALF);
      scl_m = 1'b0;
      idle(1);
   endtask

   task automatic bit_r(output bit b);
      sda_m = 1'b1;
      idle(HALF);
      scl_m = 1'b1;
      idle(HALF/2);
      b = sda_line;
      idle(HALF - HALF/2);
      scl_m = 1'b0;
      idle(1);
   endtask

   task automatic send_start();
      sda_m = 1'b1;
      idle(HALF);
      scl_m = 1'b1;
      idle(HALF);
      sda_m = 1'b0;
      idle(HALF);
      scl_m = 1'b0;
      idle(1);
   endtask

   task automatic send_stop();
      sda_m = 1'b0;
      idle(HALF);
      scl_m = 1'b1;
      idle(HALF);
      sda_m = 1'b1;
      idle(HALF);
   endtask

   task automatic wr_byte(input logic [7:0] d, input bit exp_ack_hi, input string tag);
      bit a;
      for (int i = 7; i >= 0; i--) bit_w(d[i]);
      bit_r(a);
      push_exp({tag, " ack"}, {8'h00, exp_ack_hi});
      push_obs({8'h00, a});
   endtask

   task automatic rd_byte(input bit last, input logic [7:0] e, input string tag);
      logic [7:0] d;
      for (int i = 7; i >= 0; i--) begin
         bit b;
         bit_r(b);
         d[i] = b;
      end
      bit_w(last);
      push_exp({tag, " data"}, {1'b0, e});
      push_obs({1'b0, d});
   endtask

   task automatic wr_reg(input logic [7:0] cmd, input logic [7:0] d, input bit ok, input string tag);
      send_start();
      wr_byte({DEV, 1'b0}, 1'b0, tag);
      wr_byte(cmd, !ok, tag);
      wr_byte(d, !ok, tag);
      send_stop();
      if (ok) begin
         case (cmd[1:0])
            2'd1: out_m = d;
            2'd2: pol_m = d;
            2'd3: dir_m = d;
            default: ;
         endcase
      end
   endtask

   task automatic rd_reg(input logic [7:0] cmd, input int n, input logic [7:0] e, input string tag);
      send_start();
      wr_byte({DEV, 1'b0}, 1'b0, tag);
      wr_byte(cmd, 1'b0, tag);
      send_start();
      wr_byte({DEV, 1'b1}, 1'b0, tag);
      for (int k = 0; k < n; k++) rd_byte(k == n-1, e, tag);
      send_stop();
   endtask

   task automatic chk_pins(input string tag);
      idle(4);
      push_exp({tag, " R6 oe"}, {1'b0, ~dir_m});
      push_obs({1'b0, oe});
      push_exp({tag, " R7 do"}, {1'b0, out_m ^ pol_m});
      push_obs({1'b0, dout});
   endtask

   task automatic chk_all(input string tag);
      rd_reg(8'h01, 1, out_m, tag);
      rd_reg(8'h02, 1, pol_m, tag);
      rd_reg(8'h03, 1, dir_m, tag);
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         finish_run();
      end
   end

   initial begin
      idle(5);
      rst_n = 1'b1;
      idle(5);

      // R1: reset state at the pins and in the registers
      chk_pins("R1 reset");
      chk_all("R1 reset");

      // R5: level register with zero polarity
      rd_reg(8'h00, 1, pin_drv, "R5 level");

      // R2 R6 R7: writes land and drive the pins
      wr_reg(8'h01, 8'h3C, 1'b1, "R2 out");
      wr_reg(8'h02, 8'h0F, 1'b1, "R2 pol");
      wr_reg(8'h03, 8'hF0, 1'b1, "R2 dir");
      chk_pins("R2");
      chk_all("R2 readback");

      // R5: inversion on reads, and writes to 0x00 ignored
      rd_reg(8'h00, 1, pin_drv ^ pol_m, "R5 level inv");
      wr_reg(8'h00, 8'h55, 1'b1, "R5 write");
      chk_pins("R5 after write");
      chk_all("R5 after write");
      pin_drv = 8'h3E;
      idle(4);
      rd_reg(8'h00, 1, pin_drv ^ pol_m, "R5 level new");

      // R3: commands above 0x03 are refused and touch nothing
      wr_reg(8'h04, 8'h00, 1'b0, "R3 cmd04");
      wr_reg(8'hFF, 8'h12, 1'b0, "R3 cmdFF");
      chk_pins("R3");
      chk_all("R3");

      // R4: foreign address refused, later bytes ignored
      send_start();
      wr_byte({7'h26, 1'b0}, 1'b1, "R4 addr");
      wr_byte(8'h01, 1'b1, "R4 cmd");
      wr_byte(8'h00, 1'b1, "R4 data");
      send_stop();
      chk_pins("R4");
      rd_reg(8'h01, 1, out_m, "R4 after");

      // R10: repeated reads of one register
      rd_reg(8'h02, 3, pol_m, "R10 multi");
      rd_reg(8'h03, 2, dir_m, "R10 multi dir");

      // R9: SDA pulses while SCL low
      glitch_en = 1'b1;
      wr_reg(8'h01, 8'hC3, 1'b1, "R9 glitch");
      rd_reg(8'h01, 1, out_m, "R9 glitch");
      glitch_en = 1'b0;
      chk_pins("R9");

      // R11: STOP in the middle of a data byte
      send_start();
      wr_byte({DEV, 1'b0}, 1'b0, "R11 abort");
      wr_byte(8'h01, 1'b0, "R11 abort");
      bit_w(1'b1); bit_w(1'b0); bit_w(1'b1); bit_w(1'b0);
      send_stop();
      chk_pins("R11 stop");
      rd_reg(8'h01, 1, out_m, "R11 stop");

      // R11: repeated START in the middle of the address byte
      send_start();
      bit_w(1'b0); bit_w(1'b1); bit_w(1'b0);
      wr_reg(8'h03, 8'h00, 1'b1, "R11 restart");
      chk_pins("R11 restart");
      rd_reg(8'h03, 1, dir_m, "R11 restart");

      // R8: SDA released once the bus is idle
      idle(10);
      push_exp("R8 released", 9'h000);
      push_obs({8'h00, sda_pull});

      idle(20);
      if (exp_q.size() != 0) begin
         total++;
         bad++;
         $display("FAIL scoreboard: actual=%0d pending expected=0", exp_q.size());
      end
      done = 1'b1;
      finish_run();
   end
endmodule